// File: doc/BRIEF.md
# Multi-Register Transfer Address Sequencer

This block sits behind the instruction decoder of a processor core. It turns one load-multiple or store-multiple instruction into a series of single-word memory beats. When a start strobe arrives, it captures the instruction word, the current base register value, the instruction address and the result of the condition check. It then walks the 16-bit register bitmap in the instruction. For every selected register it presents one beat that carries the word address, the register index, the transfer direction and the user-bank/PSR flag. A valid/ready handshake paces the beats.

When the last beat has been accepted, the block raises a one-cycle done pulse. In that same cycle it presents the base register number and the base value to write back, if write-back was asked for. If the condition fails, the block finishes with no beats. If the register list is empty, it finishes with no beats and raises an error. The register file, the memory and the condition evaluation belong to the neighbouring logic.

Top module: `blkx_seq`

## Requirements
- R1: After reset, `beat_valid_o`, `done_o`, `err_o`, `wb_en_o` and `busy_o` are all 0.
- R2: Instruction bits [15:0] form the register list, where bit i selects register i. Exactly one beat is issued per set bit. Beats come in ascending register index order.
- R3: The lowest selected register takes the lowest address, and each later beat is 4 bytes higher. With n selected registers, the first address is set by bit 24 (1 = pre, 0 = post) and bit 23 (1 = up, 0 = down): up/pre gives base+4, up/post gives base, down/pre gives base-4n, and down/post gives base-4n+4.
- R4: When bit 21 is 1 and the sequence ran, `wb_en_o` is high during the done cycle. In that cycle `wb_reg_o` equals bits [19:16], and `wb_value_o` is base+4n when bit 23 is 1 or base-4n when it is 0. When bit 21 is 0, `wb_en_o` stays low.
- R5: Every beat carries `beat_load_o` equal to bit 20 (1 = load, 0 = store) and `beat_user_o` equal to bit 22.
- R6: On a store beat of register 15, `beat_pc_o` is 1 and `beat_pcdata_o` equals the instruction address plus 12. On every other beat, including a load of register 15, `beat_pc_o` is 0.
- R7: If `cond_ok_i` is 0 at start, `done_o` pulses in the cycle after the start. No beat is issued, and `err_o` and `wb_en_o` stay 0.
- R8: If the condition passes and bits [15:0] are all zero, `done_o` and `err_o` pulse together in the cycle after the start. No beat is issued and `wb_en_o` stays 0.
- R9: While `beat_valid_o` is high and `beat_ready_i` is low, the beat's address, index and flags hold steady. With `beat_ready_i` held high, one beat is accepted every cycle.
- R10: The first beat is valid in the cycle after the start. `done_o` is a single-cycle pulse, due in the cycle after the last beat is accepted. A start strobe while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled only while idle |
| instr_i | input | 32 | Instruction word |
| base_i | input | 32 | Base register value |
| pc_i | input | 32 | Instruction address |
| cond_ok_i | input | 1 | Condition check passed |
| beat_ready_i | input | 1 | Memory side accepts the current beat |
| beat_valid_o | output | 1 | A beat is presented |
| beat_addr_o | output | 32 | Word address of the beat |
| beat_reg_o | output | 4 | Register index of the beat |
| beat_load_o | output | 1 | 1 = load, 0 = store |
| beat_user_o | output | 1 | PSR load / user-bank flag |
| beat_pc_o | output | 1 | Store of register 15; use `beat_pcdata_o` as data |
| beat_pcdata_o | output | 32 | Instruction address plus 12 |
| wb_en_o | output | 1 | Write back the base register this cycle |
| wb_reg_o | output | 4 | Base register number |
| wb_value_o | output | 32 | New base value |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Empty-list error, valid with `done_o` |
| busy_o | output | 1 | A sequence is in progress |

## Verification
Every output comes from a register. The first beat, or the done pulse of a skipped or erroneous instruction, is therefore due one cycle after the start edge. The done pulse with its write-back fields is due one cycle after the edge that accepts the last beat. The bench drives inputs on the falling edge and reads outputs on that same falling edge. It counts cycles from the start and compares the cycle of the first beat and the cycle of the done pulse against these figures. It stalls the ready line in a fixed pattern, so that holding the beat and accepting it on the next edge are both checked at the expected cycle.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  localparam int BX_AW     = 32;
  localparam int BX_NREG   = 16;
  localparam int BX_IDXW   = $clog2(BX_NREG);
  localparam int BX_CW     = BX_IDXW + 1;
  localparam int BX_WORD   = 4;
  localparam int BX_PC_OFS = 12;

  typedef enum logic [1:0] {BX_IDLE, BX_RUN, BX_DONE} bx_state_t;

  typedef struct packed {
    logic                pre;
    logic                up;
    logic                psr_user;
    logic                wback;
    logic                load;
    logic [BX_IDXW-1:0]  rn;
    logic [BX_NREG-1:0]  list;
  } bx_op_t;

  function automatic logic [BX_CW-1:0] bx_count(input logic [BX_NREG-1:0] l);
    logic [BX_CW-1:0] c;
    c = '0;
    for (int i = 0; i < BX_NREG; i++) c = c + BX_CW'(l[i]);
    return c;
  endfunction

  function automatic logic [BX_AW-1:0] bx_span(input logic [BX_CW-1:0] cnt);
    return BX_AW'(cnt) * BX_AW'(BX_WORD);
  endfunction

  function automatic logic [BX_AW-1:0] bx_first_addr(input logic [BX_AW-1:0] base,
                                                     input logic up, input logic pre,
                                                     input logic [BX_CW-1:0] cnt);
    if (up) return pre ? base + BX_AW'(BX_WORD) : base;
    return pre ? base - bx_span(cnt) : base - bx_span(cnt) + BX_AW'(BX_WORD);
  endfunction

  function automatic logic [BX_AW-1:0] bx_wb_value(input logic [BX_AW-1:0] base,
                                                   input logic up,
                                                   input logic [BX_CW-1:0] cnt);
    return up ? base + bx_span(cnt) : base - bx_span(cnt);
  endfunction
endpackage

// File: rtl/blkx_decode.sv
module blkx_decode
  import blkx_pkg::*;
#(
  parameter int IW = 32
) (
  input  logic [IW-1:0] instr_i,
  output bx_op_t        op_o
);
  localparam int P_BIT = 24;
  localparam int U_BIT = 23;
  localparam int S_BIT = 22;
  localparam int W_BIT = 21;
  localparam int L_BIT = 20;
  localparam int RN_LO = 16;

  always_comb begin
    op_o.pre      = instr_i[P_BIT];
    op_o.up       = instr_i[U_BIT];
    op_o.psr_user = instr_i[S_BIT];
    op_o.wback    = instr_i[W_BIT];
    op_o.load     = instr_i[L_BIT];
    op_o.rn       = instr_i[RN_LO +: BX_IDXW];
    op_o.list     = instr_i[BX_NREG-1:0];
  end
endmodule

// File: rtl/blkx_pick.sv
module blkx_pick #(
  parameter int N    = 16,
  parameter int IDXW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    mask_i,
  output logic [N-1:0]    grant_o,
  output logic [IDXW-1:0] idx_o,
  output logic            last_o
);
  logic [N-1:0] below;
  assign below[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign below[i] = below[i-1] | mask_i[i-1];
  end

  assign grant_o = mask_i & ~below;
  assign last_o  = (|mask_i) && ((mask_i & ~grant_o) == '0);

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) if (grant_o[i]) idx_o = idx_o | IDXW'(i);
  end

  assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && ((mask_i != '0) == (grant_o != '0)));
endmodule

// File: rtl/blkx_ctrl.sv
module blkx_ctrl
  import blkx_pkg::*;
#(
  parameter int AW   = BX_AW,
  parameter int N    = BX_NREG,
  parameter int IDXW = BX_IDXW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  bx_op_t          op_i,
  input  logic [AW-1:0]   base_i,
  input  logic [AW-1:0]   pc_i,
  input  logic            cond_ok_i,
  input  logic            ready_i,
  input  logic [N-1:0]    grant_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic            last_i,
  output logic [N-1:0]    mask_o,
  output logic            beat_valid_o,
  output logic [AW-1:0]   beat_addr_o,
  output logic [IDXW-1:0] beat_reg_o,
  output logic            beat_load_o,
  output logic            beat_user_o,
  output logic            beat_pc_o,
  output logic [AW-1:0]   beat_pcdata_o,
  output logic            wb_en_o,
  output logic [IDXW-1:0] wb_reg_o,
  output logic [AW-1:0]   wb_value_o,
  output logic            done_o,
  output logic            err_o,
  output logic            busy_o
);
  localparam logic [IDXW-1:0] PC_IDX = IDXW'(N - 1);

  bx_state_t       state;
  logic [N-1:0]    mask_q;
  logic [AW-1:0]   addr_q, wbval_q, pcdata_q;
  logic [IDXW-1:0] rn_q;
  logic            load_q, user_q, wback_q, ran_q, err_q;

  logic [BX_CW-1:0] cnt_in;
  logic            list_nz, take_start, accept, fire_last;

  assign cnt_in     = bx_count(op_i.list);
  assign list_nz    = |op_i.list;
  assign take_start = (state == BX_IDLE) && start_i;
  assign accept     = beat_valid_o && ready_i;
  assign fire_last  = accept && last_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= BX_IDLE;
      mask_q   <= '0;
      addr_q   <= '0;
      wbval_q  <= '0;
      pcdata_q <= '0;
      rn_q     <= '0;
      load_q   <= 1'b0;
      user_q   <= 1'b0;
      wback_q  <= 1'b0;
      ran_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      unique case (state)
        BX_IDLE: if (take_start) begin
          mask_q   <= cond_ok_i ? op_i.list : '0;
          addr_q   <= bx_first_addr(base_i, op_i.up, op_i.pre, cnt_in);
          wbval_q  <= bx_wb_value(base_i, op_i.up, cnt_in);
          pcdata_q <= pc_i + AW'(BX_PC_OFS);
          rn_q     <= op_i.rn;
          load_q   <= op_i.load;
          user_q   <= op_i.psr_user;
          wback_q  <= op_i.wback;
          ran_q    <= cond_ok_i && list_nz;
          err_q    <= cond_ok_i && !list_nz;
          state    <= (cond_ok_i && list_nz) ? BX_RUN : BX_DONE;
        end
        BX_RUN: if (accept) begin
          mask_q <= mask_q & ~grant_i;
          addr_q <= addr_q + AW'(BX_WORD);
          if (fire_last) state <= BX_DONE;
        end
        BX_DONE: state <= BX_IDLE;
        default: state <= BX_IDLE;
      endcase
    end
  end

  assign mask_o        = mask_q;
  assign beat_valid_o  = (state == BX_RUN);
  assign beat_addr_o   = addr_q;
  assign beat_reg_o    = idx_i;
  assign beat_load_o   = load_q;
  assign beat_user_o   = user_q;
  assign beat_pc_o     = beat_valid_o && !load_q && (idx_i == PC_IDX);
  assign beat_pcdata_o = pcdata_q;
  assign done_o        = (state == BX_DONE);
  assign wb_en_o       = done_o && wback_q && ran_q;
  assign wb_reg_o      = rn_q;
  assign wb_value_o    = wbval_q;
  assign err_o         = done_o && err_q;
  assign busy_o        = (state != BX_IDLE);

  assert_hold_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && !ready_i |=> beat_valid_o && $stable(beat_addr_o) && $stable(beat_reg_o));
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !last_i |=> beat_valid_o && (beat_addr_o == $past(beat_addr_o) + AW'(BX_WORD)));
  assert_reg_ascend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !last_i |=> beat_reg_o > $past(beat_reg_o));
  assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire_last |=> done_o && !beat_valid_o);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o && !wb_en_o && !beat_valid_o);
  assert_cond_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i && !cond_ok_i |=> done_o && !err_o && !wb_en_o);
  assert_pc_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_pc_o |-> beat_valid_o && !beat_load_o && (beat_reg_o == PC_IDX));
endmodule

// File: rtl/blkx_seq.sv
module blkx_seq
  import blkx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [31:0]         instr_i,
  input  logic [BX_AW-1:0]    base_i,
  input  logic [BX_AW-1:0]    pc_i,
  input  logic                cond_ok_i,
  input  logic                beat_ready_i,
  output logic                beat_valid_o,
  output logic [BX_AW-1:0]    beat_addr_o,
  output logic [BX_IDXW-1:0]  beat_reg_o,
  output logic                beat_load_o,
  output logic                beat_user_o,
  output logic                beat_pc_o,
  output logic [BX_AW-1:0]    beat_pcdata_o,
  output logic                wb_en_o,
  output logic [BX_IDXW-1:0]  wb_reg_o,
  output logic [BX_AW-1:0]    wb_value_o,
  output logic                done_o,
  output logic                err_o,
  output logic                busy_o
);
  bx_op_t               op;
  logic [BX_NREG-1:0]   mask, grant;
  logic [BX_IDXW-1:0]   idx;
  logic                 last;

  blkx_decode #(.IW(32)) u_decode (.instr_i(instr_i), .op_o(op));

  blkx_pick #(.N(BX_NREG), .IDXW(BX_IDXW)) u_pick (
    .clk(clk), .rst_n(rst_n), .mask_i(mask),
    .grant_o(grant), .idx_o(idx), .last_o(last));

  blkx_ctrl #(.AW(BX_AW), .N(BX_NREG), .IDXW(BX_IDXW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op),
    .base_i(base_i), .pc_i(pc_i), .cond_ok_i(cond_ok_i), .ready_i(beat_ready_i),
    .grant_i(grant), .idx_i(idx), .last_i(last), .mask_o(mask),
    .beat_valid_o(beat_valid_o), .beat_addr_o(beat_addr_o), .beat_reg_o(beat_reg_o),
    .beat_load_o(beat_load_o), .beat_user_o(beat_user_o), .beat_pc_o(beat_pc_o),
    .beat_pcdata_o(beat_pcdata_o), .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o),
    .wb_value_o(wb_value_o), .done_o(done_o), .err_o(err_o), .busy_o(busy_o));
endmodule

// File: tb/tb_blkx_seq.sv
module tb_blkx_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] instr_i = '0, base_i = '0, pc_i = '0;
  logic        cond_ok_i = 1'b0, beat_ready_i = 1'b0;
  logic        beat_valid_o, beat_load_o, beat_user_o, beat_pc_o;
  logic [31:0] beat_addr_o, beat_pcdata_o, wb_value_o;
  logic [3:0]  beat_reg_o, wb_reg_o;
  logic        wb_en_o, done_o, err_o, busy_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  blkx_seq dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit p, u, s, w, l, input logic [3:0] rn,
                                     input logic [15:0] list);
    return {4'hE, 3'b100, p, u, s, w, l, rn, list};
  endfunction

  task automatic run(input logic [31:0] ins, input logic [31:0] base, input logic [31:0] pc,
                     input bit cond, input int stall_mod, input bit poke);
    logic [31:0] exp_addr[16];
    logic [3:0]  exp_reg[16];
    int n = 0, got = 0, done_cyc = -1, last_acc = -1, first_cyc = -1;
    bit prev_stall = 1'b0;
    logic [31:0] prev_addr = '0, lowest;
    logic [3:0]  prev_reg = '0;
    bit done_err = 1'b0, done_wb = 1'b0;
    logic [31:0] done_wbv = '0;
    logic [3:0]  done_wbr = '0;
    bit p = ins[24], u = ins[23], w = ins[21], l = ins[20], s = ins[22];

    for (int i = 0; i < 16; i++) if (ins[i]) n++;
    // R3: lowest register at the lowest address
    if (u) lowest = p ? base + 32'd4 : base;
    else   lowest = base - 32'd4 * n + (p ? 32'd0 : 32'd4);
    begin
      int k = 0;
      for (int i = 0; i < 16; i++) if (ins[i]) begin
        exp_reg[k]  = 4'(i);
        exp_addr[k] = lowest + 32'd4 * k;
        k++;
      end
    end

    @(negedge clk);
    chk(busy_o == 1'b0, "R10", "idle before start", {31'd0, busy_o}, 32'd0);
    start_i = 1'b1; instr_i = ins; base_i = base; pc_i = pc; cond_ok_i = cond;
    @(negedge clk);
    start_i = 1'b0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      beat_ready_i = (stall_mod == 0) || ((cyc % stall_mod) != 0);
      if (poke && cyc == 1) begin
        start_i = 1'b1; instr_i = mk(0, 0, 0, 0, 0, 4'd3, 16'h0001); cond_ok_i = 1'b1;
      end
      if (poke && cyc == 2) begin
        start_i = 1'b0; instr_i = ins;
      end
      if (beat_valid_o) begin
        if (first_cyc < 0) first_cyc = cyc;
        if (prev_stall) begin
          chk(beat_addr_o == prev_addr, "R9", "addr held", beat_addr_o, prev_addr);
          chk(beat_reg_o == prev_reg, "R9", "reg held", {28'd0, beat_reg_o}, {28'd0, prev_reg});
        end
        if (beat_ready_i) begin
          if (got < n) begin
            chk(beat_reg_o == exp_reg[got], "R2", "beat reg", {28'd0, beat_reg_o}, {28'd0, exp_reg[got]});
            chk(beat_addr_o == exp_addr[got], "R3", "beat addr", beat_addr_o, exp_addr[got]);
          end
          chk(beat_load_o == l && beat_user_o == s, "R5", "load/user flags",
              {30'd0, beat_load_o, beat_user_o}, {30'd0, l, s});
          if (!l && beat_reg_o == 4'd15) begin
            chk(beat_pc_o == 1'b1, "R6", "pc flag", {31'd0, beat_pc_o}, 32'd1);
            chk(beat_pcdata_o == pc + 32'd12, "R6", "pc data", beat_pcdata_o, pc + 32'd12);
          end else
            chk(beat_pc_o == 1'b0, "R6", "no pc flag", {31'd0, beat_pc_o}, 32'd0);
          got++;
          last_acc = cyc;
        end
        prev_stall = !beat_ready_i;
        prev_addr = beat_addr_o;
        prev_reg = beat_reg_o;
      end
      if (done_o) begin
        done_cyc = cyc;
        done_err = err_o; done_wb = wb_en_o; done_wbv = wb_value_o; done_wbr = wb_reg_o;
        break;
      end
      @(negedge clk);
    end
    beat_ready_i = 1'b0;

    if (cond && n > 0) begin
      chk(got == n, "R2", "beat count", got, n);
      chk(first_cyc == 0, "R10", "first beat cycle", first_cyc, 0);
      chk(done_cyc == last_acc + 1, "R10", "done cycle", done_cyc, last_acc + 1);
      chk(done_err == 1'b0, "R8", "no err", {31'd0, done_err}, 32'd0);
      chk(done_wb == w, "R4", "wb enable", {31'd0, done_wb}, {31'd0, w});
      if (w) begin
        chk(done_wbr == ins[19:16], "R4", "wb reg", {28'd0, done_wbr}, {28'd0, ins[19:16]});
        chk(done_wbv == (u ? base + 32'd4 * n : base - 32'd4 * n), "R4", "wb value",
            done_wbv, u ? base + 32'd4 * n : base - 32'd4 * n);
      end
    end else begin
      string tag = cond ? "R8" : "R7";
      chk(got == 0 && first_cyc < 0, tag, "no beats", got, 0);
      chk(done_cyc == 0, tag, "done cycle", done_cyc, 0);
      chk(done_err == cond, tag, "err flag", {31'd0, done_err}, {31'd0, cond});
      chk(done_wb == 1'b0, tag, "no wb", {31'd0, done_wb}, 32'd0);
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R10", "done single pulse", {31'd0, done_o}, 32'd0);
  endtask

  task automatic t_reset();
    chk(!beat_valid_o && !done_o && !err_o && !wb_en_o && !busy_o, "R1", "reset outputs",
        {27'd0, beat_valid_o, done_o, err_o, wb_en_o, busy_o}, 32'd0);
  endtask

  task automatic t_store_up_post();      // R2 R3 R4 R6
    run(mk(0, 1, 0, 1, 0, 4'd13, 16'h8005), 32'h0000_1000, 32'h0000_0200, 1'b1, 0, 1'b0);
  endtask
  task automatic t_load_down_pre_stall(); // R3 R5 R9
    run(mk(1, 0, 1, 1, 1, 4'd2, 16'h00F0), 32'h0000_2000, 32'h0000_0300, 1'b1, 3, 1'b0);
  endtask
  task automatic t_store_down_post_one(); // R3 R4 no write-back
    run(mk(0, 0, 0, 0, 0, 4'd7, 16'h0001), 32'h0000_3000, 32'h0000_0400, 1'b1, 2, 1'b0);
  endtask
  task automatic t_load_up_pre_all();     // R6 load of R15, R10 busy start ignored
    run(mk(1, 1, 0, 1, 1, 4'd9, 16'hFFFF), 32'h0000_4000, 32'h0000_0500, 1'b1, 0, 1'b1);
  endtask
  task automatic t_store_down_pre_pc();   // R6 store of R15 descending
    run(mk(1, 0, 0, 1, 0, 4'd13, 16'hC002), 32'h0000_0008, 32'h0000_0600, 1'b1, 4, 1'b0);
  endtask
  task automatic t_cond_fail();           // R7
    run(mk(0, 1, 0, 1, 0, 4'd1, 16'h00FF), 32'h0000_5000, 32'h0000_0700, 1'b0, 0, 1'b0);
  endtask
  task automatic t_empty_list();          // R8
    run(mk(1, 1, 0, 1, 1, 4'd4, 16'h0000), 32'h0000_6000, 32'h0000_0800, 1'b1, 0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_store_up_post();
    t_load_down_pre_stall();
    t_store_down_post_one();
    t_load_up_pre_all();
    t_store_down_pre_pc();
    t_cond_fail();
    t_empty_list();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule